// File: doc/BRIEF.md
# Read Resynchronisation Phase Calibrator

This block sets the phase of the clock that resynchronises read data. When it is started, it first returns the tracked clock phase to step zero. It then sweeps every phase step of one clock period for each chip select in turn. At each step it waits for a compare result on the read training patterns and records whether the step passed.

A step counts as valid only if it passed on every chip select. After the sweep, the block picks the longest unbroken run of valid steps. That run may wrap from the last step back to step zero. The block then steps the phase forward to the middle of the run.

It reports the chosen phase, the run length in steps, a fail flag and an error code. Every phase change goes through a handshake toward the PLL: a single-cycle step pulse, a direction line and a counter select. Each step completes only when the PLL returns its done pulse.

Top module: `rrp_cal`

## Requirements
- R1: After reset, done_o, fail_o, pll_step_o and cmp_req_o are 0, and phase_o, win_size_o and err_o are 0.
- R2: After start_i, the block issues down steps (pll_updn_o = 0) until the tracked phase is 0, and only then makes the first compare request.
- R3: The sweep runs one chip select at a time, from 0 to CS_NUM-1. For each chip select it makes N_STEPS compare requests at phases 0, 1, ..., N_STEPS-1, in that order, with one up step (pll_updn_o = 1) after each request. cmp_cs_o names the chip select under test.
- R4: A compare passes only when cmp_btp_ok_i and cmp_mtp_ok_i are both 1 while cmp_vld_i is high. A phase step is valid only if it passed on every chip select.
- R5: Each step is a one-cycle pll_step_o pulse. No further step pulse and no compare request is issued until pll_done_i has answered the step before, and pll_updn_o holds while a step is outstanding.
- R6: The window is the longest contiguous run of valid steps, treating the steps as a ring so that a run may cross from N_STEPS-1 to 0. win_size_o reports its length.
- R7: The final phase is (first step of the window + length/2) mod N_STEPS. The block reaches it with up steps from phase 0, and phase_o matches the phase the PLL holds.
- R8: When two windows have the same length, the one found first in the ring scan wins. This is the one whose first step is lowest.
- R9: If no step is valid, fail_o = 1, err_o = 8'h01, win_size_o = 0 and phase_o stays at 0.
- R10: If every step is valid, win_size_o = N_STEPS and the final phase is N_STEPS/2.
- R11: done_o rises when calibration ends. It and all result outputs hold until the next start_i, and on success err_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts a calibration |
| pll_step_o | output | 1 | One-cycle phase step pulse |
| pll_updn_o | output | 1 | Step direction: 1 = up, 0 = down |
| pll_cntsel_o | output | CSEL_W | PLL counter select of the resync clock |
| pll_done_i | input | 1 | PLL acknowledge of the last step |
| cmp_req_o | output | 1 | Request for a compare at the current phase |
| cmp_cs_o | output | CSW | Chip select under test |
| cmp_vld_i | input | 1 | Compare result is valid |
| cmp_btp_ok_i | input | 1 | Block pattern 00001111 read back correctly |
| cmp_mtp_ok_i | input | 1 | Memory pattern 00110101 read back correctly |
| done_o | output | 1 | Calibration finished |
| fail_o | output | 1 | No valid window found |
| err_o | output | 8 | Error code, 0 on success |
| phase_o | output | PW | Tracked resync phase |
| win_size_o | output | LW | Valid window length in steps |

## Verification
The sweep is driven with the following pass patterns:
- a plain centred window;
- a window that wraps across step zero;
- two chip selects whose windows only partly overlap;
- two windows of different lengths;
- two windows of equal length;
- a window cut short by the memory pattern alone;
- no valid step;
- every step valid.

Each pattern separates one fault from the others: wrap handling, ANDing across chip selects, picking the larger window, the tie rule, requiring both patterns to pass, the fail path and the full-ring special case. Runs follow each other with no reset in between. This means every run starts from the phase the previous run left, so the return to step zero is exercised with nonzero start phases. A PLL model also checks that step pulses and compare requests never overlap an outstanding step.

// File: rtl/rrp_pkg.sv
package rrp_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RST_GO, S_RST_WAIT, S_CMP_REQ, S_CMP_WAIT,
    S_SWP_GO, S_SWP_WAIT, S_EVAL, S_SEEK_GO, S_SEEK_WAIT, S_DONE
  } cal_state_e;

  localparam logic [7:0] ERR_NONE   = 8'h00;
  localparam logic [7:0] ERR_NO_WIN = 8'h01;
endpackage

// File: rtl/rrp_step_ctrl.sv
module rrp_step_ctrl #(
  parameter int N_STEPS = 16,
  localparam int PW = $clog2(N_STEPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          dir_i,
  input  logic          done_i,
  output logic          step_o,
  output logic          dir_o,
  output logic          busy_o,
  output logic          ack_o,
  output logic [PW-1:0] phase_o
);
  logic step_q, dir_q, busy_q, ack_q;
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= 1'b0;
      dir_q   <= 1'b1;
      busy_q  <= 1'b0;
      ack_q   <= 1'b0;
      phase_q <= '0;
    end else begin
      step_q <= 1'b0;
      ack_q  <= 1'b0;
      if (go_i && !busy_q) begin
        busy_q <= 1'b1;
        step_q <= 1'b1;
        dir_q  <= dir_i;
      end else if (busy_q && !step_q && done_i) begin
        busy_q <= 1'b0;
        ack_q  <= 1'b1;
        if (dir_q)
          phase_q <= (phase_q == PW'(N_STEPS-1)) ? '0 : phase_q + 1'b1;
        else
          phase_q <= (phase_q == '0) ? PW'(N_STEPS-1) : phase_q - 1'b1;
      end
    end
  end

  assign step_o  = step_q;
  assign dir_o   = dir_q;
  assign busy_o  = busy_q;
  assign ack_o   = ack_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/rrp_win_find.sv
module rrp_win_find #(
  parameter int N_STEPS = 16,
  localparam int PW = $clog2(N_STEPS),
  localparam int LW = $clog2(N_STEPS + 1)
) (
  input  logic [N_STEPS-1:0] mask_i,
  output logic [LW-1:0]      len_o,
  output logic [PW-1:0]      centre_o
);
  int run, best, best_end, first, mid;

  // ring scan over two laps; strict compare keeps the earliest of equal runs
  always_comb begin
    run = 0; best = 0; best_end = 0;
    for (int i = 0; i < 2*N_STEPS; i++) begin
      if (mask_i[i % N_STEPS]) run = run + 1;
      else run = 0;
      if (run > best && run < N_STEPS) begin
        best = run;
        best_end = i;
      end
    end
    if (&mask_i) begin
      best = N_STEPS;
      first = 0;
    end else begin
      first = (best_end - best + 1) % N_STEPS;
    end
    mid = (first + best / 2) % N_STEPS;
    len_o    = LW'(best);
    centre_o = PW'(mid);
  end
endmodule

// File: rtl/rrp_cal.sv
module rrp_cal
  import rrp_pkg::*;
#(
  parameter int          N_STEPS  = 16,
  parameter int          CS_NUM   = 2,
  parameter int          CSEL_W   = 4,
  parameter int unsigned CSEL_VAL = 6,
  localparam int PW  = $clog2(N_STEPS),
  localparam int LW  = $clog2(N_STEPS + 1),
  localparam int CSW = (CS_NUM > 1) ? $clog2(CS_NUM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              pll_step_o,
  output logic              pll_updn_o,
  output logic [CSEL_W-1:0] pll_cntsel_o,
  input  logic              pll_done_i,
  output logic              cmp_req_o,
  output logic [CSW-1:0]    cmp_cs_o,
  input  logic              cmp_vld_i,
  input  logic              cmp_btp_ok_i,
  input  logic              cmp_mtp_ok_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [7:0]        err_o,
  output logic [PW-1:0]     phase_o,
  output logic [LW-1:0]     win_size_o
);
  cal_state_e state_q;
  logic [N_STEPS-1:0] mask_q;
  logic [PW-1:0] idx_q, seek_q, cur_phase, centre;
  logic [CSW-1:0] cs_q;
  logic [LW-1:0] len, win_q;
  logic go, dir, busy, ack, done_q, fail_q;
  logic [7:0] err_q;

  rrp_step_ctrl #(.N_STEPS(N_STEPS)) u_step (
    .clk_i, .rst_ni, .go_i(go), .dir_i(dir), .done_i(pll_done_i),
    .step_o(pll_step_o), .dir_o(pll_updn_o), .busy_o(busy), .ack_o(ack),
    .phase_o(cur_phase)
  );

  rrp_win_find #(.N_STEPS(N_STEPS)) u_win (
    .mask_i(mask_q), .len_o(len), .centre_o(centre)
  );

  always_comb begin
    go  = 1'b0;
    dir = 1'b1;
    unique case (state_q)
      S_RST_GO:  if (cur_phase != '0) begin go = 1'b1; dir = 1'b0; end
      S_SWP_GO:  go = 1'b1;
      S_SEEK_GO: if (seek_q != '0) go = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mask_q  <= '1;
      idx_q   <= '0;
      cs_q    <= '0;
      seek_q  <= '0;
      win_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE: if (start_i) begin
          state_q <= S_RST_GO;
          mask_q  <= '1;
          idx_q   <= '0;
          cs_q    <= '0;
          win_q   <= '0;
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          err_q   <= ERR_NONE;
        end
        S_RST_GO:   state_q <= (cur_phase == '0) ? S_CMP_REQ : S_RST_WAIT;
        S_RST_WAIT: if (ack) state_q <= S_RST_GO;
        S_CMP_REQ:  state_q <= S_CMP_WAIT;
        S_CMP_WAIT: if (cmp_vld_i) begin
          mask_q[idx_q] <= mask_q[idx_q] & cmp_btp_ok_i & cmp_mtp_ok_i;
          state_q <= S_SWP_GO;
        end
        S_SWP_GO:   state_q <= S_SWP_WAIT;
        S_SWP_WAIT: if (ack) begin
          if (idx_q == PW'(N_STEPS-1)) begin
            idx_q <= '0;
            if (cs_q == CSW'(CS_NUM-1)) state_q <= S_EVAL;
            else begin
              cs_q    <= cs_q + 1'b1;
              state_q <= S_CMP_REQ;
            end
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_CMP_REQ;
          end
        end
        S_EVAL: begin
          win_q <= len;
          if (len == '0) begin
            fail_q  <= 1'b1;
            err_q   <= ERR_NO_WIN;
            done_q  <= 1'b1;
            state_q <= S_DONE;
          end else begin
            seek_q  <= centre;
            state_q <= S_SEEK_GO;
          end
        end
        S_SEEK_GO: if (seek_q == '0) begin
          done_q  <= 1'b1;
          state_q <= S_DONE;
        end else state_q <= S_SEEK_WAIT;
        S_SEEK_WAIT: if (ack) begin
          seek_q  <= seek_q - 1'b1;
          state_q <= S_SEEK_GO;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pll_cntsel_o = CSEL_W'(CSEL_VAL);
  assign cmp_req_o    = (state_q == S_CMP_REQ);
  assign cmp_cs_o     = cs_q;
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign err_o        = err_q;
  assign phase_o      = cur_phase;
  assign win_size_o   = win_q;
endmodule

// File: rtl/rrp_cal_chk.sv
module rrp_cal_chk #(
  parameter int N_STEPS = 16,
  localparam int PW = $clog2(N_STEPS),
  localparam int LW = $clog2(N_STEPS + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          pll_step_o,
  input logic          pll_updn_o,
  input logic          pll_done_i,
  input logic          cmp_req_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [7:0]    err_o,
  input logic [PW-1:0] phase_o,
  input logic [LW-1:0] win_size_o
);
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (pll_step_o) pend_q <= 1'b1;
    else if (pll_done_i) pend_q <= 1'b0;
  end

  p_no_step_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_step_o |-> !pend_q);
  p_no_cmp_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_req_o |-> !pend_q);
  p_dir_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !pll_step_o) |-> $stable(pll_updn_o));
  p_fail_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (err_o != 8'h00 && phase_o == '0 && win_size_o == '0));
  p_pass_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o) |-> (err_o == 8'h00 && win_size_o != '0));
  p_win_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_size_o <= LW'(N_STEPS));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> ($stable(phase_o) && done_o && !pll_step_o));
endmodule

bind rrp_cal rrp_cal_chk #(.N_STEPS(N_STEPS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .pll_step_o(pll_step_o), .pll_updn_o(pll_updn_o), .pll_done_i(pll_done_i),
  .cmp_req_o(cmp_req_o), .done_o(done_o), .fail_o(fail_o), .err_o(err_o),
  .phase_o(phase_o), .win_size_o(win_size_o)
);

// File: tb/rrp_cal_tb.sv
module rrp_cal_tb;
  localparam int N = 16;
  localparam int NCS = 2;

  typedef struct {
    int phase; int win; int fail; int err; string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic step, updn, done_p = 0, creq, vld = 0, btp = 0, mtp = 0;
  logic [3:0] cntsel;
  logic [0:0] cs;
  logic done, fail;
  logic [7:0] err;
  logic [3:0] phase;
  logic [4:0] win;

  int checks = 0, fails = 0;
  exp_t q[$];
  logic [N-1:0] btp_m [NCS];
  logic [N-1:0] mtp_m [NCS];
  int pll_ph = 0, pdly = 0, pdir = 1, viol = 0;
  int cdly = 0, ccs = 0, cph = 0, ncmp = 0, order_err = 0;
  logic done_prev = 0;

  always #10 clk = ~clk;

  rrp_cal u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pll_step_o(step), .pll_updn_o(updn), .pll_cntsel_o(cntsel), .pll_done_i(done_p),
    .cmp_req_o(creq), .cmp_cs_o(cs), .cmp_vld_i(vld),
    .cmp_btp_ok_i(btp), .cmp_mtp_ok_i(mtp),
    .done_o(done), .fail_o(fail), .err_o(err), .phase_o(phase), .win_size_o(win)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // PLL and compare models, sampled away from the active edge
  always @(negedge clk) begin
    done_p = 0;
    if (pdly > 0) begin
      pdly--;
      if (pdly == 0) begin
        done_p = 1;
        pll_ph = pdir ? (pll_ph + 1) % N : (pll_ph + N - 1) % N;
      end
    end
    if (step) begin
      if (pdly != 0) viol++;
      pdly = 3;
      pdir = updn;
    end
    vld = 0;
    if (cdly > 0) begin
      cdly--;
      if (cdly == 0) begin
        vld = 1;
        btp = btp_m[ccs][cph];
        mtp = mtp_m[ccs][cph];
      end
    end
    if (creq) begin
      if (pdly != 0) viol++;
      if (int'(cs) != ncmp / N || pll_ph != ncmp % N) order_err++;
      ccs = int'(cs);
      cph = pll_ph;
      cdly = 2;
      ncmp++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done && !done_prev && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(int'(phase) == e.phase, {e.tag, " R7 phase"}, int'(phase), e.phase);
      chk(int'(win) == e.win, {e.tag, " R6 window"}, int'(win), e.win);
      chk(int'(fail) == e.fail, {e.tag, " R9 fail"}, int'(fail), e.fail);
      chk(int'(err) == e.err, {e.tag, " R11 err"}, int'(err), e.err);
      chk(pll_ph == int'(phase), {e.tag, " R7 pll phase"}, pll_ph, int'(phase));
      chk(ncmp == N*NCS, {e.tag, " R3 compare count"}, ncmp, N*NCS);
      chk(order_err == 0, {e.tag, " R2 R3 compare order"}, order_err, 0);
      chk(viol == 0, {e.tag, " R5 handshake"}, viol, 0);
    end
    done_prev = done;
  end

  task automatic run_cal(input logic [N-1:0] b0, input logic [N-1:0] m0,
                         input logic [N-1:0] b1, input logic [N-1:0] m1,
                         input int ep, input int ew, input int ef, input int ee,
                         input string tag);
    exp_t e;
    btp_m[0] = b0; mtp_m[0] = m0; btp_m[1] = b1; mtp_m[1] = m1;
    e.phase = ep; e.win = ew; e.fail = ef; e.err = ee; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    ncmp = 0; order_err = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    wait (q.size() == 0);
    repeat (4) @(negedge clk);
    chk(done == 1 && int'(phase) == ep, {tag, " R11 hold"}, int'(phase), ep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0 && fail == 0 && step == 0 && creq == 0, "R1 flags", int'(done), 0);
    chk(phase == 0 && win == 0 && err == 0, "R1 values", int'(phase), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(int'(cntsel) == 6, "R5 counter select", int'(cntsel), 6);
    run_cal(16'h0FF0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8, 8, 0, 0, "centred R6");
    run_cal(16'hC00F, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1, 6, 0, 0, "wrap R6 R2");
    run_cal(16'h00FF, 16'hFFFF, 16'h0FF0, 16'hFFFF, 6, 4, 0, 0, "two cs R4");
    run_cal(16'h7C0E, 16'hFFFF, 16'hFFFF, 16'hFFFF, 12, 5, 0, 0, "largest R6");
    run_cal(16'hFFFF, 16'h0FFF, 16'hFFF0, 16'hFFFF, 8, 8, 0, 0, "pattern R4");
    run_cal(16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0, 1, 1, "none R9");
    run_cal(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8, 16, 0, 0, "full R10");
    run_cal(16'h0E1C, 16'hFFFF, 16'hFFFF, 16'hFFFF, 3, 3, 0, 0, "tie R8");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule